// File: doc/BRIEF.md
# Sampling Converter Serial Read Port

This block models the digital read-out side of a 16-bit sampling converter. It runs entirely on a fast system clock. It watches three host-driven lines: a convert strobe, a serial data input and a serial clock. It drives one serial data output, an output-enable for that line and a high-impedance flag. The conversion result arrives on a parallel input. The conversion time is a fixed number of system-clock cycles, counted by an internal timer, and the serial clock plays no part in it.

Each rising edge of the convert strobe starts a conversion and latches the interface mode from the serial input level. With the serial input high the port works in select mode: the output is driven only while an enabling line is low, either the strobe itself (three-wire use) or the serial input with the strobe held high (four-wire use). With the serial input low the port works in chain mode: the 16-bit register becomes a shift stage between the serial input and the output, so several converters can share one data line. In both modes the result is read MSB first, and each falling serial-clock edge presents the next bit.

Top module: `sar_serial_port`

## Requirements
- R1: After reset the output-enable is 0 and the high-impedance flag is 1. The high-impedance flag is always the inverse of the output-enable.
- R2: At every rising edge of the convert strobe the serial input level is latched as the mode: 1 selects select mode and 0 selects chain mode.
- R3: In select mode, a strobe rising edge starts a conversion lasting CONV_CYCLES system cycles, and the output stays undriven from that edge until the conversion ends.
- R4: In select mode, once the conversion has ended and the enabling line is low, the MSB of the value present on the result input at the end of the conversion is driven at once. Later changes of the result input have no effect.
- R5: In select mode, each falling serial-clock edge while enabled presents the next lower bit, so 16 bits are delivered MSB first.
- R6: In select mode the output returns to high impedance after the 16th falling serial-clock edge, even while the enabling line stays low.
- R7: In select mode the output returns to high impedance as soon as the enabling line goes high, even before all 16 bits have been read.
- R8: In four-wire select use, with the strobe held high, a low serial input enables the output.
- R9: In chain mode the output is driven continuously. The result MSB appears when the conversion ends, and each falling serial-clock edge shifts the register left with the serial input entering at bit 0, so an input level reaches the output 16 falling edges later.
- R10: In chain mode, when the strobe and the serial input are both low, the output is driven low.
- R11: Falling serial-clock edges that occur during a conversion are ignored, so the first bit read afterwards is still the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert strobe from host (asynchronous) |
| sdi_i | input | 1 | Serial data / mode-select input (asynchronous) |
| sck_i | input | 1 | Serial clock from host (asynchronous) |
| result_i | input | DATA_W | Parallel conversion result, loaded when conversion ends |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output-enable for sdo_o |
| sdo_hiz_o | output | 1 | High when sdo_o is released |

## Verification
Two functions can fall in the same system cycle. The first is the end of conversion, which loads the register. The second is a serial-clock falling edge, which shifts the register. A falling edge is deliberately issued while the conversion timer is still running. The first bit read afterwards is then judged against the MSB of the loaded result, which shows that the early edge neither shifted nor corrupted the load. The same reasoning covers a strobe edge that arrives while bits are still being read: the early release check raises the strobe mid-read and expects the output to be undriven.

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              sdi_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sdo_hiz_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W + 1);

  logic [SYNC_STAGES-1:0] cnv_sync, sdi_sync, sck_sync;
  logic cnv_q, sck_q;
  logic chain_mode, busy, valid;
  logic [CNT_W-1:0]  conv_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;

  wire cnv_s    = cnv_sync[SYNC_STAGES-1];
  wire sdi_s    = sdi_sync[SYNC_STAGES-1];
  wire sck_s    = sck_sync[SYNC_STAGES-1];
  wire cnv_rise = cnv_s & ~cnv_q;
  wire sck_fall = sck_q & ~sck_s;
  wire cs_en    = ~cnv_s | ~sdi_s;
  wire cs_done  = (bit_cnt == BIT_W'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_sync <= '0;
      sdi_sync <= '0;
      sck_sync <= '0;
      cnv_q    <= 1'b0;
      sck_q    <= 1'b0;
    end else begin
      cnv_sync <= {cnv_sync[SYNC_STAGES-2:0], cnv_i};
      sdi_sync <= {sdi_sync[SYNC_STAGES-2:0], sdi_i};
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      cnv_q    <= cnv_s;
      sck_q    <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_mode <= 1'b0;
      busy       <= 1'b0;
      valid      <= 1'b0;
      conv_cnt   <= '0;
      bit_cnt    <= '0;
      shreg      <= '0;
    end else if (cnv_rise) begin
      chain_mode <= ~sdi_s;
      busy       <= 1'b1;
      valid      <= 1'b0;
      conv_cnt   <= CNT_W'(CONV_CYCLES - 1);
      bit_cnt    <= '0;
    end else if (busy) begin
      if (conv_cnt == '0) begin
        busy  <= 1'b0;
        valid <= 1'b1;
        shreg <= result_i;
      end else begin
        conv_cnt <= conv_cnt - 1'b1;
      end
    end else if (sck_fall && valid) begin
      if (chain_mode) begin
        shreg <= {shreg[DATA_W-2:0], sdi_s};
      end else if (cs_en && !cs_done) begin
        shreg   <= {shreg[DATA_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign sdo_oe_o  = chain_mode | (valid & ~busy & cs_en & ~cs_done);
  assign sdo_hiz_o = ~sdo_oe_o;
  assign sdo_o     = !sdo_oe_o ? 1'b0 :
                     (chain_mode && (busy || (!cnv_s && !sdi_s))) ? 1'b0 :
                     shreg[DATA_W-1];

  a_r2_mode_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise |=> (chain_mode == !$past(sdi_s)));

  a_r3_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_rise && sdi_s) |=> !sdo_oe_o);

  a_r6_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_mode && cs_done) |-> !sdo_oe_o);

  a_r9_chain_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnv_rise && !busy && valid && chain_mode && sck_fall) |=> (shreg[0] == $past(sdi_s)));

  a_r11_sck_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_cnt != '0 && sck_fall) |=> $stable(shreg));
endmodule

// File: tb/tb_sar_serial_port.sv
module tb_sar_serial_port;
  localparam int DATA_W = 16;
  localparam int CONV   = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnv = 1'b0, sdi = 1'b1, sck = 1'b0;
  logic [DATA_W-1:0] result = '0;
  logic sdo, sdo_oe, sdo_hiz;

  always #2 clk = ~clk;

  sar_serial_port #(.DATA_W(DATA_W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sdi_i(sdi), .sck_i(sck),
    .result_i(result), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdo_hiz_o(sdo_hiz));

  typedef struct { string req; logic oe; logic dat; } exp_t;
  exp_t q[$];
  event chk_ev;
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  initial forever begin
    exp_t e;
    @(chk_ev);
    @(negedge clk);
    e = q.pop_front();
    vectors++;
    if (sdo_oe !== e.oe || sdo_hiz !== !e.oe || (e.oe && sdo !== e.dat)) begin
      miscompares++;
      $display("FAIL %s: oe=%b hiz=%b sdo=%b, expected oe=%b hiz=%b sdo=%b",
               e.req, sdo_oe, sdo_hiz, sdo, e.oe, !e.oe, e.dat);
    end
  end

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, logic oe, logic dat);
    exp_t e;
    settle();
    e.req = req; e.oe = oe; e.dat = dat;
    q.push_back(e);
    -> chk_ev;
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic sck_pulse();
    sck = 1'b1; settle();
    sck = 1'b0; settle();
  endtask

  task automatic wait_conv();
    repeat (CONV + 10) @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] pat;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 reset released", 1'b0, 1'b0);
    rst_n = 1'b1;
    expect_out("R1 idle after reset", 1'b0, 1'b0);

    // three-wire select mode
    r = 16'hA5C3; result = r; sdi = 1'b1;
    cnv = 1'b1;
    expect_out("R2/R3 select mode, undriven during conversion", 1'b0, 1'b0);
    sck_pulse();  // R11: edge during conversion
    expect_out("R3 still undriven", 1'b0, 1'b0);
    wait_conv();
    result = 16'h0000;
    cnv = 1'b0;
    expect_out("R4/R11 MSB on enable", 1'b1, r[15]);
    for (int k = 1; k < DATA_W; k++) begin
      sck_pulse();
      expect_out("R5 next bit", 1'b1, r[15-k]);
    end
    sck_pulse();
    expect_out("R6 released after 16th edge", 1'b0, 1'b0);

    // early release by strobe going high
    r = 16'h3C0F; result = r;
    cnv = 1'b1;
    wait_conv();
    cnv = 1'b0;
    expect_out("R4 MSB", 1'b1, r[15]);
    for (int k = 1; k < 3; k++) begin
      sck_pulse();
      expect_out("R5 bit", 1'b1, r[15-k]);
    end
    r = 16'h8001; result = r;
    cnv = 1'b1;
    expect_out("R7 early release by strobe", 1'b0, 1'b0);
    wait_conv();
    result = 16'h7777;

    // four-wire use: strobe held high, serial input enables
    expect_out("R8 undriven while input high", 1'b0, 1'b0);
    sdi = 1'b0;
    expect_out("R8 enable by input low", 1'b1, r[15]);
    sck_pulse();
    expect_out("R8/R5 second bit", 1'b1, r[14]);
    sdi = 1'b1;
    expect_out("R7 early release by input", 1'b0, 1'b0);

    // chain mode
    cnv = 1'b0; settle();
    sdi = 1'b0; settle();
    r = 16'hF00D; result = r;
    cnv = 1'b1;
    expect_out("R2/R9 chain mode driven low during conversion", 1'b1, 1'b0);
    wait_conv();
    result = 16'h0000;
    expect_out("R9 chain MSB after conversion", 1'b1, r[15]);
    pat = 16'h9234;
    for (int k = 0; k < DATA_W; k++) begin
      sdi = pat[15-k];
      sck_pulse();
      if (k < DATA_W - 1)
        expect_out("R9 chain result bit", 1'b1, r[14-k]);
    end
    expect_out("R9 first shifted-in level after 16 edges", 1'b1, pat[15]);
    sck_pulse();
    expect_out("R9 second shifted-in level", 1'b1, pat[14]);
    sdi = 1'b1; sck_pulse();
    expect_out("R9 third shifted-in level", 1'b1, pat[13]);
    sdi = 1'b1; sck_pulse();
    expect_out("R9 fourth level before strobe low", 1'b1, pat[12]);
    sck_pulse();
    expect_out("R9 fifth level", 1'b1, pat[11]);
    sck_pulse();
    expect_out("R9 sixth level", 1'b1, pat[10]);
    cnv = 1'b0;
    expect_out("R10 strobe low, input high keeps data", 1'b1, pat[10]);
    sdi = 1'b0;
    expect_out("R10 strobe and input low force zero", 1'b1, 1'b0);

    repeat (4) @(posedge clk);
    finished = 1;
    report();
  end
endmodule